// File: doc/BRIEF.md
# Burst-Aware Round-Robin Memory Arbiter

This block decides which of several bus masters owns a shared memory controller port. Each master raises a request and describes its transfer. A transfer is a single access, a burst with a declared number of beats, or an open-ended incrementing burst. The memory side pulses a beat-accepted strobe for every beat of the owner's transfer that it takes. The arbiter drives a registered one-hot grant and a grant-valid flag.

Ownership changes only at safe points, so a burst in flight is never split. The safe points are:
- the port is idle;
- the accepted beat of a single access;
- the final beat of a sized burst;
- every fourth accepted beat of an open-ended burst;
- the owner withdrawing its request.

At a safe point a rotating-priority search picks the next owner. The master just granted moves to the back of the line. An override input can force a specific requesting master to be chosen, but it has effect only at a safe point.

Top module: `burst_rr_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the grant becomes all zero and `gnt_valid` low after that edge. The next search then starts at master 0.
- R2: When the port is idle and several masters request together, the lowest-index requester is granted on the first clock edge after the requests are seen.
- R3: After master i is granted, the next search starts at master i+1, wrapping from the highest index to 0. The master just granted therefore has the lowest priority.
- R4: Between safe points the grant stays unchanged, even when other masters request.
- R5: Each master's kind field is `xfer_kind[2i+1:2i]`, with 0 = single, 1 = sized burst, 2 = open-ended burst and 3 = single. For a single access, the edge carrying the accepted beat is a safe point.
- R6: Each master's beat count is `xfer_len[i*LEN_W +: LEN_W]`. For a sized burst, the edge carrying the accepted beat that brings the count of accepted beats up to that length is a safe point. A length of 0 behaves like 1.
- R7: For an open-ended burst, the edges carrying the 4th, 8th, 12th ... accepted beat are safe points. Cycles with `beat_ok` low do not advance the count.
- R8: An edge at which the current owner has its request low is a safe point.
- R9: If no master requests at a safe point, the grant clears and `gnt_valid` drops. The rotation position is kept, so the next search starts after the last granted master.
- R10: When `ovr_req` is high at a safe point and master `ovr_idx` is requesting, that master is granted and the rotation continues after it. At any other edge, or for a non-requesting target, the override is ignored.
- R11: `gnt` has at most one bit set, and `gnt_valid` is high exactly when one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MST | Request, one bit per master |
| xfer_kind | input | 2*N_MST | Transfer kind, two bits per master |
| xfer_len | input | N_MST*LEN_W | Declared beat count of a sized burst, per master |
| beat_ok | input | 1 | One beat of the owner's transfer accepted this cycle |
| ovr_req | input | 1 | Override request |
| ovr_idx | input | IDX_W | Master targeted by the override |
| gnt | output | N_MST | One-hot grant |
| gnt_valid | output | 1 | A master owns the port |

## Verification
The bench first applies simultaneous requests from an idle port. This separates fixed lowest-index priority from true rotation, and shows wrap-around and that the rotation position is kept once all requests drop. It then holds a sized burst against competing requests with stalled beats, to show the grant is held and the hand-over falls on exactly the declared beat, including a zero length. Open-ended bursts with gaps in `beat_ok` show that only accepted beats move the four-beat boundary. Override stimulus applied off and on safe points, and aimed at requesting and idle masters, separates an honoured override from an ignored one.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_FIXED  = 2'd1,
    KIND_OPEN   = 2'd2,
    KIND_RSVD   = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N_MST = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_MST-1:0] req,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Search in rotating order beginning at 'start'; first hit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N_MST; k++) begin
      int c;
      c = int'(start) + k;
      if (c >= N_MST) c = c - N_MST;
      if (!found && req[c]) begin
        found = 1'b1;
        idx   = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/beat_tracker.sv
module beat_tracker
  import arb_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int OPEN_SPAN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  xfer_kind_e kind_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic       active,
  input  logic       beat_ok,
  output logic       last_beat
);
  localparam int SPAN_W = (OPEN_SPAN > 1) ? $clog2(OPEN_SPAN) : 1;

  xfer_kind_e       kind_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + (LEN_W+1)'(1);

  always_comb begin
    last_beat = 1'b0;
    if (active && beat_ok) begin
      case (kind_q)
        KIND_FIXED: last_beat = (cnt_next >= {1'b0, len_q});
        KIND_OPEN:  last_beat = (cnt_q[SPAN_W-1:0] == {SPAN_W{1'b1}});
        default:    last_beat = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= KIND_SINGLE;
      len_q  <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      kind_q <= kind_in;
      len_q  <= len_in;
      cnt_q  <= '0;
    end else if (active && beat_ok) begin
      cnt_q <= cnt_next[LEN_W-1:0];
    end
  end

  // R6/R7: a new transfer always starts counting from zero
  assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == '0));

  // R7: only accepted beats move the count
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && !beat_ok) |=> $stable(cnt_q));
endmodule

// File: rtl/burst_rr_arbiter.sv
module burst_rr_arbiter
  import arb_pkg::*;
#(
  parameter int N_MST     = 4,
  parameter int LEN_W     = 8,
  parameter int OPEN_SPAN = 4,
  parameter int IDX_W     = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_MST-1:0]       req,
  input  logic [2*N_MST-1:0]     xfer_kind,
  input  logic [N_MST*LEN_W-1:0] xfer_len,
  input  logic                   beat_ok,
  input  logic                   ovr_req,
  input  logic [IDX_W-1:0]       ovr_idx,
  output logic [N_MST-1:0]       gnt,
  output logic                   gnt_valid
);
  xfer_kind_e       kind_arr [N_MST];
  logic [LEN_W-1:0] len_arr  [N_MST];

  for (genvar g = 0; g < N_MST; g++) begin : g_unpack
    assign kind_arr[g] = xfer_kind_e'(xfer_kind[2*g +: 2]);
    assign len_arr[g]  = xfer_len[g*LEN_W +: LEN_W];
  end

  logic [N_MST-1:0] gnt_q;
  logic             gnt_valid_q;
  logic [IDX_W-1:0] owner_q;
  logic [IDX_W-1:0] start_q;

  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             last_beat;
  logic             owner_drop;
  logic             arb_pt;
  logic             ovr_hit;
  logic             any_win;
  logic [IDX_W-1:0] chosen;
  logic [IDX_W-1:0] chosen_next;
  logic             load;

  rr_picker #(.N_MST(N_MST), .IDX_W(IDX_W)) i_picker (
    .req   (req),
    .start (start_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign owner_drop = gnt_valid_q && !req[owner_q];
  assign arb_pt     = !gnt_valid_q || owner_drop || last_beat;
  assign ovr_hit    = ovr_req && (int'(ovr_idx) < N_MST) && req[ovr_idx];
  assign chosen     = ovr_hit ? ovr_idx : pick_idx;
  assign any_win    = ovr_hit || pick_found;
  assign load       = arb_pt && any_win;
  assign chosen_next = (int'(chosen) == N_MST - 1) ? '0 : chosen + IDX_W'(1);

  beat_tracker #(.LEN_W(LEN_W), .OPEN_SPAN(OPEN_SPAN)) i_tracker (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .kind_in   (kind_arr[chosen]),
    .len_in    (len_arr[chosen]),
    .active    (gnt_valid_q),
    .beat_ok   (beat_ok),
    .last_beat (last_beat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q       <= '0;
      gnt_valid_q <= 1'b0;
      owner_q     <= '0;
      start_q     <= '0;
    end else if (arb_pt) begin
      if (any_win) begin
        gnt_q       <= N_MST'(1) << chosen;
        gnt_valid_q <= 1'b1;
        owner_q     <= chosen;
        start_q     <= chosen_next;
      end else begin
        gnt_q       <= '0;
        gnt_valid_q <= 1'b0;
      end
    end
  end

  assign gnt       = gnt_q;
  assign gnt_valid = gnt_valid_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (gnt_q == '0 && !gnt_valid_q));

  assert_hold_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid_q && req[owner_q] && !last_beat) |=> $stable(gnt_q));

  assert_idle_drop_R9: assert property (@(posedge clk) disable iff (rst)
    ((!gnt_valid_q || last_beat) && req == '0) |=> !gnt_valid_q);

  assert_override_R10: assert property (@(posedge clk) disable iff (rst)
    ((!gnt_valid_q || last_beat) && ovr_req && (int'(ovr_idx) < N_MST) && req[ovr_idx])
      |=> gnt_q[$past(ovr_idx)]);

  assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q) && (gnt_valid_q == (gnt_q != '0)));
endmodule

// File: tb/test_burst_rr_arbiter.sv
module test_burst_rr_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int LW    = 8;
  localparam int IW    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [2*N-1:0] kind = '0;
  logic [N*LW-1:0] blen = '0;
  logic          beat_ok = 1'b0;
  logic          ovr_req = 1'b0;
  logic [IW-1:0] ovr_idx = '0;
  logic [N-1:0]  gnt;
  logic          gnt_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_rr_arbiter #(.N_MST(N), .LEN_W(LW), .OPEN_SPAN(4)) i_burst_rr_arbiter (
    .clk(clk), .rst(rst), .req(req), .xfer_kind(kind), .xfer_len(blen),
    .beat_ok(beat_ok), .ovr_req(ovr_req), .ovr_idx(ovr_idx),
    .gnt(gnt), .gnt_valid(gnt_valid)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Compares grant and valid; R11 consistency is checked on every call.
  task automatic check_gnt(string tag, logic [N-1:0] exp);
    n_chk++;
    if (gnt !== exp || gnt_valid !== (exp != '0)) begin
      n_bad++;
      $display("FAIL %s: gnt=%b valid=%b expected gnt=%b valid=%b",
               tag, gnt, gnt_valid, exp, (exp != '0));
    end
  endtask

  task automatic set_kind(int m, logic [1:0] k);
    kind[2*m +: 2] = k;
  endtask

  task automatic set_len(int m, logic [LW-1:0] l);
    blen[m*LW +: LW] = l;
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; beat_ok = 1'b0; ovr_req = 1'b0; kind = '0; blen = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check_gnt("R1 reset idle", 4'b0000);
  endtask

  task automatic t_rotation();
    do_reset();
    req = 4'b1110;
    step();
    check_gnt("R2 lowest index first", 4'b0010);
    beat_ok = 1'b1;
    step();
    check_gnt("R3 R5 rotate after single", 4'b0100);
    step();
    check_gnt("R3 rotate to 3", 4'b1000);
    step();
    check_gnt("R3 wrap around", 4'b0010);
    beat_ok = 1'b0; req = '0;
    step();
    check_gnt("R8 R9 drop to idle", 4'b0000);
    req = 4'b1011;
    step();
    check_gnt("R9 pointer kept", 4'b1000);
  endtask

  task automatic t_fixed();
    do_reset();
    set_kind(0, 2'd1); set_len(0, 8'd4);
    set_kind(1, 2'd1); set_len(1, 8'd0);
    req = 4'b0001;
    step();
    check_gnt("R2 single requester", 4'b0001);
    req = 4'b1111;
    step(); step(); step();
    check_gnt("R4 hold while stalled", 4'b0001);
    beat_ok = 1'b1;
    step(); step(); step();
    check_gnt("R4 R6 hold before last beat", 4'b0001);
    step();
    check_gnt("R6 switch on last beat", 4'b0010);
    step();
    check_gnt("R6 zero length acts as one", 4'b0100);
    beat_ok = 1'b0;
  endtask

  task automatic t_open();
    do_reset();
    set_kind(2, 2'd2); set_kind(3, 2'd2);
    req = 4'b1100;
    step();
    check_gnt("R2 open burst owner", 4'b0100);
    beat_ok = 1'b1; step(); step();
    beat_ok = 1'b0; step(); step();
    beat_ok = 1'b1; step();
    check_gnt("R7 gaps do not count", 4'b0100);
    step();
    check_gnt("R7 fourth beat boundary", 4'b1000);
    step(); step(); step();
    check_gnt("R7 hold before boundary", 4'b1000);
    step();
    check_gnt("R7 R3 wrap after boundary", 4'b0100);
    beat_ok = 1'b0;
  endtask

  task automatic t_override();
    do_reset();
    req = 4'b0111;
    step();
    check_gnt("R2 override setup", 4'b0001);
    ovr_req = 1'b1; ovr_idx = 2'd2;
    step();
    check_gnt("R10 ignored off safe point", 4'b0001);
    beat_ok = 1'b1;
    step();
    check_gnt("R10 honoured at safe point", 4'b0100);
    ovr_req = 1'b0;
    step();
    check_gnt("R10 rotation after override", 4'b0001);
    ovr_req = 1'b1; ovr_idx = 2'd3;
    step();
    check_gnt("R10 idle target ignored", 4'b0010);
    ovr_req = 1'b0; beat_ok = 1'b0;
  endtask

  initial begin
    t_reset();
    t_rotation();
    t_fixed();
    t_open();
    t_override();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule